// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It watches the incoming line, which idles high. A falling edge, once it has been synchronised, marks a candidate start bit. The block then counts receiver-clock cycles so that every later bit is sampled close to the middle of its bit period. Data bits arrive least significant bit first and are followed by an optional parity bit and one stop bit. Once the stop bit has been sampled, the character, its error flags and a ready flag appear on the parallel side.

The mode inputs choose the character length, the parity and the oversampling factor. They are shared with the companion transmitter and must stay stable while a character is being received. The host enables reception with a command bit. It reads a character by pulsing a read strobe, and that strobe drops the ready flag. The receiver clock is the block clock, so one receiver-clock cycle is one `clk_i` cycle.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_data_o` is 0 and `rx_rdy_o`, `par_err_o`, `frm_err_o` and `ovr_err_o` are all 0.
- R2: While `rx_en_i` is 0 no character is received and the receive sequencer stays idle. Clearing `rx_en_i` in the middle of a character abandons it.
- R3: `rxd_i` passes through a two-flop synchroniser, and only a high-to-low transition of the synchronised line can start a character. At factor 16 or 64 the line must still be low F/2 clocks after the edge. If it is not, the receiver goes back to idle and produces no character.
- R4: `baud_sel_i` selects the factor F: 2'b00 is 1, 2'b01 is 16, and 2'b1x is 64. After the start bit, the line is sampled once every F clocks, and data arrives least significant bit first. At factor 1 there is no half-bit check, and the first data bit is sampled on the clock after the edge is seen.
- R5: `char_len_i` sets the number of data bits to 5 plus its value (2'b00 gives 5 bits, 2'b11 gives 8). Any output bit above the character length reads 0.
- R6: When `par_en_i` is 1, a parity bit follows the last data bit. Under even parity (`par_odd_i`=0) that bit must equal the XOR of the data bits. Under odd parity it must equal the inverse of that XOR. If it does not, `par_err_o` is 1 for that character.
- R7: `frm_err_o` is 1 for a character whose sampled stop bit is low.
- R8: When the stop bit has been sampled, the character and its parity and framing flags are loaded and `rx_rdy_o` goes to 1 on the same clock edge. A `rd_i` pulse with no character completing in that cycle clears `rx_rdy_o`.
- R9: If a character completes while `rx_rdy_o` is 1 and `rd_i` is 0, the new character replaces the old one and `ovr_err_o` goes to 1. If `rd_i` is 1 in the same cycle a character completes, `ovr_err_o` stays 0 and `rx_rdy_o` stays 1 with the new character. A read clears `ovr_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block and receiver clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive-enable command bit |
| baud_sel_i | input | 2 | Oversampling factor select |
| char_len_i | input | 2 | Character length code (5 + value) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| rxd_i | input | 1 | Serial input line, idles high |
| rd_i | input | 1 | Host read strobe for the holding buffer |
| rx_data_o | output | 8 | Received character, upper bits zero-filled |
| rx_rdy_o | output | 1 | Character waiting in the holding buffer |
| par_err_o | output | 1 | Parity mismatch on the held character |
| frm_err_o | output | 1 | Stop bit sampled low on the held character |
| ovr_err_o | output | 1 | A held character was overwritten before it was read |

## Verification
The riskiest coincidence is a character completing in the same cycle as a host read. In that cycle the read and the new load both drive the ready and overrun flags. The bench runs at factor 1, where the stop-bit sample falls exactly twelve clocks after the start bit is driven. It forks the read pulse so that the strobe lands on that edge. The pass condition is that ready stays high with the second character and overrun stays low. A separate run without the read must set overrun.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             at_zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero_o = (cnt_q == '0);
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      rdy_o     <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
    end else if (done_i) begin
      data_o    <= data_i;
      rdy_o     <= 1'b1;
      par_err_o <= par_err_i;
      frm_err_o <= frm_err_i;
      // a read in the completion cycle consumes the old character
      ovr_err_o <= rdy_o & ~rd_i;
    end else if (rd_i) begin
      rdy_o     <= 1'b0;
      ovr_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_BITS = 5,
  parameter int unsigned FAC_MID  = 16,
  parameter int unsigned FAC_HI   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic [1:0]        baud_sel_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_rdy_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);
  localparam int unsigned CNT_W  = $clog2(FAC_HI);
  localparam int unsigned BCNT_W = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic              rxd_s, rxd_prev_q, fall;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val, full_m1, half_m1;
  logic [BCNT_W-1:0] bit_cnt_q, last_idx, shamt;
  logic [DATA_W-1:0] sh_q, aligned;
  logic              par_q, do_shift, do_par, char_done, rx_busy;
  logic              par_bad, exp_par;

  rx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .at_zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_prev_q <= 1'b1;
    else         rxd_prev_q <= rxd_s;
  end
  assign fall = rxd_prev_q & ~rxd_s;

  always_comb begin
    unique case (baud_sel_i)
      2'b00:   begin full_m1 = '0;                 half_m1 = '0;                   end
      2'b01:   begin full_m1 = CNT_W'(FAC_MID - 1); half_m1 = CNT_W'(FAC_MID/2 - 1); end
      default: begin full_m1 = CNT_W'(FAC_HI - 1);  half_m1 = CNT_W'(FAC_HI/2 - 1);  end
    endcase
  end

  assign last_idx = BCNT_W'(MIN_BITS - 1) + BCNT_W'(char_len_i);
  assign shamt    = BCNT_W'(DATA_W - 1) - last_idx;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = full_m1;
    do_shift  = 1'b0;
    do_par    = 1'b0;
    char_done = 1'b0;
    if (!rx_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fall) begin
          tmr_load = 1'b1;
          if (baud_sel_i == 2'b00) begin
            state_d = ST_DATA;
            tmr_val = '0;
          end else begin
            state_d = ST_START;
            tmr_val = half_m1;
          end
        end
        ST_START: if (tmr_zero) begin
          if (!rxd_s) begin
            state_d  = ST_DATA;
            tmr_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_DATA: if (tmr_zero) begin
          do_shift = 1'b1;
          tmr_load = 1'b1;
          if (bit_cnt_q == last_idx) state_d = par_en_i ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (tmr_zero) begin
          do_par   = 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_STOP;
        end
        ST_STOP: if (tmr_zero) begin
          char_done = 1'b1;
          state_d   = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) bit_cnt_q <= '0;
      else if (do_shift)      bit_cnt_q <= bit_cnt_q + 1'b1;
      if (do_shift) sh_q  <= {rxd_s, sh_q[DATA_W-1:1]};
      if (do_par)   par_q <= rxd_s;
    end
  end

  // right-justify the shifted character; vacated upper bits become zero
  assign aligned = sh_q >> shamt;
  assign exp_par = (^aligned) ^ par_odd_i;
  assign par_bad = par_en_i & (par_q != exp_par);
  assign rx_busy = (state_q != ST_IDLE);

  rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (char_done),
    .rd_i     (rd_i),
    .data_i   (aligned),
    .par_err_i(par_bad),
    .frm_err_i(~rxd_s),
    .data_o   (rx_data_o),
    .rdy_o    (rx_rdy_o),
    .par_err_o(par_err_o),
    .frm_err_o(frm_err_o),
    .ovr_err_o(ovr_err_o)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MIN_BITS = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic [1:0]        char_len_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_rdy_o,
  input logic              ovr_err_o,
  input logic              rx_busy,
  input logic              char_done
);
  p_idle_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_busy);

  p_rdy_from_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_rdy_o) |-> $past(char_done));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !char_done) |=> !rx_rdy_o);

  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done && char_len_i == 2'b00) |=> (rx_data_o[DATA_W-1:MIN_BITS] == '0));

  p_ovr_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(rx_rdy_o && char_done && !rd_i));

  p_no_ovr_on_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done && rd_i) |=> !ovr_err_o);
endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_en_i   (rx_en_i),
  .rd_i      (rd_i),
  .char_len_i(char_len_i),
  .rx_data_o (rx_data_o),
  .rx_rdy_o  (rx_rdy_o),
  .ovr_err_o (ovr_err_o),
  .rx_busy   (rx_busy),
  .char_done (char_done)
);

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic [1:0] baud_sel = 2'b01;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rxd = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_rdy, par_err, frm_err, ovr_err;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done_flag = 1'b0;

  always #5 clk = ~clk;

  serial_rx_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .baud_sel_i(baud_sel),
    .char_len_i(char_len), .par_en_i(par_en), .par_odd_i(par_odd),
    .rxd_i(rxd), .rd_i(rd), .rx_data_o(rx_data), .rx_rdy_o(rx_rdy),
    .par_err_o(par_err), .frm_err_o(frm_err), .ovr_err_o(ovr_err)
  );

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] len;
    logic       pen;
    logic       odd;
    logic [1:0] fsel;
    logic       bad_par;
    logic       bad_stop;
    logic [7:0] exp_data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 2'b11, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 8'hA5},
    '{8'h3C, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h1C},
    '{8'h5A, 2'b01, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 8'h1A},
    '{8'hFF, 2'b10, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 8'h7F},
    '{8'h81, 2'b11, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 8'h81},
    '{8'h6E, 2'b10, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h6E}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int factor_of(input logic [1:0] sel);
    if (sel == 2'b00) return 1;
    if (sel == 2'b01) return 16;
    return 64;
  endfunction

  task automatic drive_bit(input logic b, input int f);
    rxd = b;
    repeat (f) @(posedge clk);
    @(negedge clk);
  endtask

  // call at a negedge; modes must already be set
  task automatic send_char(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int f, nb;
    logic [7:0] mask;
    f    = factor_of(baud_sel);
    nb   = 5 + int'(char_len);
    mask = 8'hFF >> (8 - nb);
    drive_bit(1'b0, f);
    for (int i = 0; i < nb; i++) drive_bit(d[i], f);
    if (par_en) drive_bit((^(d & mask)) ^ par_odd ^ bad_par, f);
    drive_bit(~bad_stop, f);
    rxd = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_read();
    rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] fs, input logic [1:0] ln, input logic pe, input logic od);
    baud_sel = fs; char_len = ln; par_en = pe; par_odd = od;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 data", rx_data, 0);
    check("R1 flags", {rx_rdy, par_err, frm_err, ovr_err}, 0);

    // vector table: R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      set_mode(VECS[v].fsel, VECS[v].len, VECS[v].pen, VECS[v].odd);
      repeat (2) @(negedge clk);
      send_char(VECS[v].data, VECS[v].bad_par, VECS[v].bad_stop);
      settle();
      check($sformatf("R4/R5 vec%0d data", v), rx_data, VECS[v].exp_data);
      check($sformatf("R6/R7/R8 vec%0d rdy,pe,fe,ovr", v), {rx_rdy, par_err, frm_err, ovr_err},
            {1'b1, VECS[v].bad_par, VECS[v].bad_stop, 1'b0});
      host_read();
      check($sformatf("R8 vec%0d read clears rdy", v), rx_rdy, 0);
    end

    // R3 short low pulse at factor 16 is rejected
    set_mode(2'b01, 2'b11, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R3 false start gives no character", rx_rdy, 0);
    send_char(8'hC3, 1'b0, 1'b0);
    settle();
    check("R3 receive after false start", {rx_rdy, rx_data}, {1'b1, 8'hC3});
    host_read();

    // R2 disabled receiver ignores a full character
    rx_en = 1'b0;
    @(negedge clk);
    send_char(8'h5A, 1'b0, 1'b0);
    settle();
    check("R2 disabled, no ready", rx_rdy, 0);
    check("R2 disabled, buffer untouched", rx_data, 8'hC3);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    send_char(8'h96, 1'b0, 1'b0);
    settle();
    check("R2 enabled again", {rx_rdy, rx_data}, {1'b1, 8'h96});
    host_read();

    // R9 overrun without read
    send_char(8'h11, 1'b0, 1'b0);
    settle();
    send_char(8'h22, 1'b0, 1'b0);
    settle();
    check("R9 overrun set", {rx_rdy, ovr_err, rx_data}, {1'b1, 1'b1, 8'h22});
    host_read();
    check("R9 read clears overrun", {rx_rdy, ovr_err}, 2'b00);

    // R9 read lands on the completion edge (factor 1, 8 bits, no parity)
    set_mode(2'b00, 2'b11, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    send_char(8'h33, 1'b0, 1'b0);
    settle();
    check("R9 first char held", {rx_rdy, rx_data}, {1'b1, 8'h33});
    fork
      send_char(8'h4D, 1'b0, 1'b0);
      begin
        repeat (11) @(posedge clk);
        @(negedge clk);
        rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
      end
    join
    settle();
    check("R9 coincident read, new char ready", {rx_rdy, rx_data}, {1'b1, 8'h4D});
    check("R9 coincident read, no overrun", ovr_err, 0);
    host_read();
    check("R8 final read clears rdy", rx_rdy, 0);

    report();
  end
endmodule